// File: doc/BRIEF.md
# Discrete-Input Serial Slave Interface

This block is the digital side of an eight-channel discrete-input receiver. It is a serial slave with two shift registers, and a register-select pin picks one of them for each chip-select frame. The data register is parallel-in, serial-out. It takes a snapshot of eight already-digitized channel levels at the start of a frame, and the host then clocks them out. The configuration register is serial-in, parallel-out and is nine bits long. While the host clocks in a new setting, the present setting comes out on the serial output. The new setting is copied to a held output latch when the frame ends.

All serial pins are synchronized into one system clock, and edges are detected there. The system clock must run at least four times faster than the serial clock. Several devices can share one chip select and one serial clock in a daisy chain, because data shifted in at the input reappears at the output after one register length. A commit-enable input lets the host shift without updating the latch.

Top module: `discin_spi`

## Requirements
- R1: The register select (1 = data register, 0 = configuration register) is sampled when chip select falls and is held for the whole frame. A change of `sel_i` during a frame does not switch registers.
- R2: While chip select is high, `sdo_oe_o` is 0 and serial-clock edges leave both registers unchanged.
- R3: In a data frame, the falling edge of chip select loads `chan_i` into the data register in parallel, with `chan_i[k]` holding channel k+1. A low level reads as 0 and a high level reads as 1.
- R4: Each rising serial-clock edge during a frame moves `sdi_i` into bit 0 of the selected register and shifts every bit one place toward the MSB.
- R5: `sdo_o` presents the MSB of the selected register. In a data frame, channel 8 (`chan_i[7]`) comes out first and channel 1 comes out last.
- R6: In a configuration frame, the rising edge of chip select copies the 9-bit shift contents to `cfg_o`, which then holds between frames.
- R7: During a configuration write, the bits of the present configuration come out first. A bit entering on `sdi_i` reaches `sdo_o` 8 serial clocks later in a data frame and 9 serial clocks later in a configuration frame.
- R8: Reset clears the data register, the configuration shift register and `cfg_o` to zero, and drives `sdo_oe_o` to 0.
- R9: When `commit_en_i` is low at the rising edge of chip select, `cfg_o` is not updated. The shifted bits stay in the shift register and come out in the next configuration frame.
- R10: `sdo_oe_o` goes high on the third system-clock edge after chip select is first sampled low. Every register action follows its pin edge with the same three-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Register select: 1 data, 0 configuration |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| chan_i | input | DATA_W | Digitized channel levels, bit k = channel k+1 |
| commit_en_i | input | 1 | Configuration commit enable, low blocks the latch update |
| sdo_o | output | 1 | Serial data out (MSB of the selected register) |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| cfg_o | output | CFG_W | Latched configuration outputs |

## Verification
Each pin edge takes three system-clock edges to act: two synchronizer stages and one registered update. The bench therefore changes inputs on falling clock edges and never samples a result before three rising edges have passed. The serial clock runs with four system clocks per phase, so `sdo_o` is read just before each rising serial-clock edge. At that point the previous shift settled at least five cycles earlier, and the frame's first bit settled four cycles after chip select fell. The latch output and the output enable are checked several cycles after chip select rises. The exact enable latency is probed once, on the second and third edges.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  typedef enum logic {
    FR_CFG  = 1'b0,
    FR_DATA = 1'b1
  } frame_sel_e;
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsi_edge.sv
module dsi_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= d;
  end

  assign rise = d & ~prev_q;
  assign fall = ~d & prev_q;
endmodule

// File: rtl/dsi_shreg.sv
module dsi_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] pdata,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= pdata;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/discin_spi.sv
module discin_spi #(
  parameter int DATA_W = 8,
  parameter int CFG_W = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sel_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] chan_i,
  input  logic              commit_en_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [CFG_W-1:0]  cfg_o
);
  import dsi_pkg::*;

  localparam int SYNC_W = DATA_W + 4;
  // chip select idles high, everything else idles low
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1);

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              cs_s, sck_s, sdi_s, sel_s;
  logic [DATA_W-1:0] chan_s;

  assign raw_bus = {chan_i, sel_i, sdi_i, sck_i, cs_n_i};

  dsi_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  assign cs_s   = sync_bus[0];
  assign sck_s  = sync_bus[1];
  assign sdi_s  = sync_bus[2];
  assign sel_s  = sync_bus[3];
  assign chan_s = sync_bus[SYNC_W-1:4];

  logic cs_rise, cs_fall, sck_rise, sck_fall_unused;

  dsi_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst(rst), .d(cs_s), .rise(cs_rise), .fall(cs_fall)
  );

  dsi_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst(rst), .d(sck_s), .rise(sck_rise), .fall(sck_fall_unused)
  );

  // frame state: active flag and the register chosen at frame start
  logic       frame_q;
  frame_sel_e sel_frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q     <= 1'b0;
      sel_frame_q <= FR_CFG;
    end else if (cs_fall) begin
      frame_q     <= 1'b1;
      sel_frame_q <= frame_sel_e'(sel_s);
    end else if (cs_rise) begin
      frame_q     <= 1'b0;
    end
  end

  logic shift_en, data_load, data_shift, cfg_shift, cfg_commit;

  assign shift_en   = sck_rise & frame_q & ~cs_s;
  assign data_load  = cs_fall & (frame_sel_e'(sel_s) == FR_DATA);
  assign data_shift = shift_en & (sel_frame_q == FR_DATA);
  assign cfg_shift  = shift_en & (sel_frame_q == FR_CFG);
  assign cfg_commit = cs_rise & frame_q & (sel_frame_q == FR_CFG) & commit_en_i;

  logic [DATA_W-1:0] data_q;
  logic [CFG_W-1:0]  cfg_sr_q;
  logic [CFG_W-1:0]  cfg_lat_q;

  dsi_shreg #(.W(DATA_W)) u_data_sr (
    .clk(clk), .rst(rst), .load(data_load), .shift(data_shift),
    .pdata(chan_s), .sin(sdi_s), .q(data_q)
  );

  dsi_shreg #(.W(CFG_W)) u_cfg_sr (
    .clk(clk), .rst(rst), .load(1'b0), .shift(cfg_shift),
    .pdata('0), .sin(sdi_s), .q(cfg_sr_q)
  );

  always_ff @(posedge clk) begin
    if (rst)             cfg_lat_q <= '0;
    else if (cfg_commit) cfg_lat_q <= cfg_sr_q;
  end

  assign sdo_o    = (sel_frame_q == FR_DATA) ? data_q[DATA_W-1] : cfg_sr_q[CFG_W-1];
  assign sdo_oe_o = frame_q;
  assign cfg_o    = cfg_lat_q;
endmodule

// File: rtl/discin_spi_chk.sv
module discin_spi_chk #(
  parameter int DATA_W = 8,
  parameter int CFG_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_i,
  input logic              commit_en_i,
  input logic              sdo_oe_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic              sel_frame,
  input logic [DATA_W-1:0] data_q
);
  p_select_held_r1: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe_o && $past(sdo_oe_o)) |-> $stable(sel_frame));

  p_idle_hiz_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o);

  p_data_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_q) |-> sdo_oe_o);

  p_commit_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> (!sdo_oe_o && $past(sdo_oe_o)));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o == '0 && !sdo_oe_o));

  p_commit_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> $past(commit_en_i));
endmodule

bind discin_spi discin_spi_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n_i(cs_n_i), .commit_en_i(commit_en_i),
  .sdo_oe_o(sdo_oe_o), .cfg_o(cfg_o), .sel_frame(sel_frame_q), .data_q(data_q)
);

// File: tb/discin_spi_test.sv
module discin_spi_test;
  localparam int DW = 8;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, sel = 1'b1, sck = 1'b0, sdi = 1'b0, commit_en = 1'b1;
  logic [DW-1:0] chan = '0;
  logic          sdo, sdo_oe;
  logic [CW-1:0] cfg;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  discin_spi uut (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
    .chan_i(chan), .commit_en_i(commit_en), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one chip-select frame of n serial clocks, sending tx MSB first
  task automatic frame(input logic s, input int n, input logic [31:0] tx,
                       input bit flip, output logic [31:0] rx);
    rx = '0;
    sel = s;
    wclk(4);
    cs_n = 1'b0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      sdi = tx[n-1-i];
      if (flip && i == 2) sel = ~s;
      wclk(4);
      rx = {rx[30:0], sdo};
      sck = 1'b1;
      wclk(4);
      sck = 1'b0;
    end
    wclk(2);
    cs_n = 1'b1;
    wclk(6);
    sel = s;
  endtask

  logic [31:0] rx;
  logic [CW-1:0] model_cfg = '0;

  initial begin
    wclk(3);
    rst = 1'b0;
    wclk(1);
    chk("R8 cfg after reset", 32'(cfg), 0);
    chk("R8 oe after reset", 32'(sdo_oe), 0);
    frame(1'b0, CW, 0, 0, rx);
    chk("R8 cfg shift reg reset", rx, 0);
    frame(1'b1, DW, 0, 0, rx);
    chk("R8 data reg read after zero load", rx, 0);

    // R10 enable latency
    sel = 1'b1;
    wclk(4);
    cs_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 oe low after two edges", 32'(sdo_oe), 0);
    @(posedge clk); @(negedge clk);
    chk("R10 oe high after three edges", 32'(sdo_oe), 1);
    wclk(4);
    cs_n = 1'b1;
    wclk(6);
    chk("R2 oe low when deselected", 32'(sdo_oe), 0);

    // R3 R5: sweep all channel patterns
    for (int v = 0; v < (1 << DW); v++) begin
      chan = DW'(v);
      frame(1'b1, DW, 32'((v * 37) ^ 8'h5A), 0, rx);
      chk("R3 R5 data read", rx, 32'(v));
    end

    // R7 R4: data daisy chain of two register lengths
    for (int v = 0; v < 8; v++) begin
      logic [15:0] tx = 16'((v * 16'h1F3B) ^ 16'hA5C3);
      chan = DW'(v * 29 + 3);
      frame(1'b1, 2 * DW, 32'(tx), 0, rx);
      chk("R7 R4 data daisy chain", rx, 32'({chan, tx[15:8]}));
    end

    // R6 R7: sweep all configuration values
    for (int v = 0; v < (1 << CW); v++) begin
      logic [CW-1:0] nv = CW'(v ^ 9'h0A5);
      frame(1'b0, CW, 32'(nv), 0, rx);
      chk("R7 present cfg shifted out", rx, 32'(model_cfg));
      chk("R6 cfg committed", 32'(cfg), 32'(nv));
      model_cfg = nv;
    end

    // R7 R4: configuration daisy chain
    begin
      logic [2*CW-1:0] tx = 18'h2D3C5;
      frame(1'b0, 2 * CW, 32'(tx), 0, rx);
      chk("R7 R4 cfg daisy chain", rx, 32'({model_cfg, tx[2*CW-1:CW]}));
      chk("R6 cfg from last bits", 32'(cfg), 32'(tx[CW-1:0]));
      model_cfg = tx[CW-1:0];
    end

    // R2: serial clocks while deselected change nothing
    for (int i = 0; i < 12; i++) begin
      sdi = i[0];
      sel = i[1];
      wclk(4); sck = 1'b1; wclk(4); sck = 1'b0;
      chk("R2 oe stays low", 32'(sdo_oe), 0);
    end
    chk("R2 cfg unchanged", 32'(cfg), 32'(model_cfg));
    frame(1'b0, CW, 32'(model_cfg), 0, rx);
    chk("R2 cfg shift reg untouched", rx, 32'(model_cfg));
    chan = 8'hC3;
    frame(1'b1, DW, 0, 0, rx);
    chk("R2 data reg reload", rx, 32'h0C3);

    // R9: blocked commit keeps latch, shifted bits still present
    commit_en = 1'b0;
    frame(1'b0, CW, 32'h1B6, 0, rx);
    chk("R9 latch held when blocked", 32'(cfg), 32'(model_cfg));
    commit_en = 1'b1;
    frame(1'b0, CW, 32'h049, 0, rx);
    chk("R9 blocked bits shifted out", rx, 32'h1B6);
    chk("R9 commit after re-enable", 32'(cfg), 32'h049);
    model_cfg = 9'h049;

    // R1: select flipped mid-frame does not switch registers
    chan = 8'h96;
    frame(1'b1, DW, 32'h0FF, 1, rx);
    chk("R1 data frame holds selection", rx, 32'h096);
    chk("R1 cfg untouched by data frame", 32'(cfg), 32'(model_cfg));
    frame(1'b0, CW, 32'h133, 1, rx);
    chk("R1 cfg frame holds selection", rx, 32'(model_cfg));
    chk("R1 cfg committed despite select change", 32'(cfg), 32'h133);

    // R8: reset in mid-life clears the latch
    rst = 1'b1;
    wclk(2);
    rst = 1'b0;
    wclk(1);
    chk("R8 cfg cleared by reset", 32'(cfg), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule